// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This unit turns the already-synchronized values of a general-purpose I/O port into one interrupt line per pin. The pin count is a parameter and defaults to 32. Each pin has four trigger detectors: a 0-to-1 change, a 1-to-0 change, a high level and a low level. Each detector has its own enable bit. When an enabled trigger fires, it sets the pin's bit in an interrupt-state register. The pin's interrupt output is that state bit gated by a per-pin interrupt-enable bit.

Software uses a single-cycle register port. A write strobe carries an address and a data word, and the read data is a combinational function of the address. State bits are cleared by writing ones to them. A write-only test register forces chosen state bits one cycle after it is written, and then empties itself. Input synchronizers, pull control and any bus adapter sit outside this unit.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, the state, interrupt-enable and all four trigger-enable registers read 0, and every interrupt output is 0.
- R2: If the rising trigger is enabled for a pin, and the pin is 1 while it was 0 one clock earlier, the pin's state bit is 1 after the next clock edge.
- R3: If the falling trigger is enabled for a pin, and the pin is 0 while it was 1 one clock earlier, the pin's state bit is 1 after the next clock edge.
- R4: An enabled high-level or low-level trigger sets the state bit on every clock while its level persists. A clear therefore takes effect only on a clock where the level condition is absent.
- R5: A trigger whose enable bit is 0 never sets a state bit, whatever the pin does.
- R6: Writing to the state register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: When a trigger sets a bit on the same clock that software clears it, the bit ends up 1.
- R8: Test-register bits written as 1 are ORed into the state one clock after the write. The test register then returns to 0, and it always reads as 0.
- R9: A pin's interrupt output is 1 exactly when its state bit and its interrupt-enable bit are both 1.
- R10: A pin held high through reset causes no rising event after reset, even when the rising trigger is enabled on the first clock after reset.
- R11: Register addresses on the 3-bit address: 0 state, 1 interrupt enable, 2 test, 3 rising enable, 4 falling enable, 5 high-level enable, 6 low-level enable. A written enable register reads back its value right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Synchronized pin values |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address, for both writes and reads |
| regWrData | input | NUM_PINS | Write data |
| regRdData | output | NUM_PINS | Combinational read data for regAddr |
| irqOut | output | NUM_PINS | Per-pin interrupt lines |

## Verification
A pin change or level, and any register write, that is present before a clock edge shows in the state register and the interrupt outputs just after that edge. A test-register write is the exception: its bits reach the state one edge later, because they pass through the test register first. The bench drives inputs on the falling edge and queues the values expected after the following rising edge. A monitor then compares the read data and the interrupt lines one nanosecond after that rising edge, so every comparison falls in the cycle in which its result is due.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATE  = 3'd0,
    SEL_ENABLE = 3'd1,
    SEL_TEST   = 3'd2,
    SEL_RISE   = 3'd3,
    SEL_FALL   = 3'd4,
    SEL_HIGH   = 3'd5,
    SEL_LOW    = 3'd6,
    SEL_NONE   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic clrState;
    logic wrEnable;
    logic wrTest;
    logic wrRise;
    logic wrFall;
    logic wrHigh;
    logic wrLow;
  } wrStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output wrStrobe_t         strobes,
  output regSel_e           rdSel
);
  regSel_e sel;

  always_comb begin
    sel = regSel_e'(regAddr);
    rdSel = sel;
    strobes = '0;
    if (regWrEn) begin
      case (sel)
        SEL_STATE:  strobes.clrState = 1'b1;
        SEL_ENABLE: strobes.wrEnable = 1'b1;
        SEL_TEST:   strobes.wrTest   = 1'b1;
        SEL_RISE:   strobes.wrRise   = 1'b1;
        SEL_FALL:   strobes.wrFall   = 1'b1;
        SEL_HIGH:   strobes.wrHigh   = 1'b1;
        SEL_LOW:    strobes.wrLow    = 1'b1;
        default:    strobes = '0;
      endcase
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes)) else $error("write strobes not exclusive"); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> (strobes == '0)) else $error("strobe without write"); // R11
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] wrData,
  input  wrStrobe_t           strobes,
  input  regSel_e             rdSel,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] irqOut
);
  localparam int NUM_TRIG = 4;
  localparam logic [NUM_PINS-1:0] ALL_ZERO = '0;

  logic [NUM_PINS-1:0] prevPin;
  logic [NUM_PINS-1:0] riseEn, fallEn, highEn, lowEn;
  logic [NUM_PINS-1:0] intEnable;
  logic [NUM_PINS-1:0] state;
  logic [NUM_PINS-1:0] testPend;
  logic [NUM_PINS-1:0] hwSet;
  logic [NUM_PINS-1:0] clrMask;
  logic [NUM_PINS-1:0] stateNext;

  // Per-pin trigger detectors
  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    logic [NUM_TRIG-1:0] hit;
    assign hit[0] = riseEn[p] &  pinIn[p] & ~prevPin[p];
    assign hit[1] = fallEn[p] & ~pinIn[p] &  prevPin[p];
    assign hit[2] = highEn[p] &  pinIn[p];
    assign hit[3] = lowEn[p]  & ~pinIn[p];
    assign hwSet[p] = |hit;
  end

  assign clrMask   = strobes.clrState ? wrData : ALL_ZERO;
  assign stateNext = (state & ~clrMask) | hwSet | testPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPin   <= '0;
      riseEn    <= '0;
      fallEn    <= '0;
      highEn    <= '0;
      lowEn     <= '0;
      intEnable <= '0;
      state     <= '0;
      testPend  <= '0;
    end else begin
      prevPin  <= pinIn;
      state    <= stateNext;
      testPend <= strobes.wrTest ? wrData : ALL_ZERO;
      if (strobes.wrRise)   riseEn    <= wrData;
      if (strobes.wrFall)   fallEn    <= wrData;
      if (strobes.wrHigh)   highEn    <= wrData;
      if (strobes.wrLow)    lowEn     <= wrData;
      if (strobes.wrEnable) intEnable <= wrData;
    end
  end

  assign irqOut = state & intEnable;

  always_comb begin
    case (rdSel)
      SEL_STATE:  rdData = state;
      SEL_ENABLE: rdData = intEnable;
      SEL_RISE:   rdData = riseEn;
      SEL_FALL:   rdData = fallEn;
      SEL_HIGH:   rdData = highEn;
      SEL_LOW:    rdData = lowEn;
      default:    rdData = '0;
    endcase
  end

  AST_TEST_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (testPend != '0) |=> ((state & $past(testPend)) == $past(testPend)))
    else $error("test bit not applied"); // R8
  AST_TEST_ONESHOT: assert property (@(posedge clk) disable iff (!rstN)
    ((testPend != '0) && !strobes.wrTest) |=> (testPend == '0))
    else $error("test value lingered"); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ((hwSet & clrMask) != '0) |=> ((state & $past(hwSet & clrMask)) == $past(hwSet & clrMask)))
    else $error("clear beat a set event"); // R7
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (hwSet == '0 && testPend == '0 && !strobes.clrState) |=> $stable(state))
    else $error("state moved without cause"); // R6
  AST_IRQ_NEEDS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    ((irqOut & ~state) == '0)) else $error("irq without state"); // R9
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [NUM_PINS-1:0] regWrData,
  output logic [NUM_PINS-1:0] regRdData,
  output logic [NUM_PINS-1:0] irqOut
);
  wrStrobe_t strobes;
  regSel_e   rdSel;

  gpio_irq_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  gpio_irq_dp #(.NUM_PINS(NUM_PINS)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .wrData  (regWrData),
    .strobes (strobes),
    .rdSel   (rdSel),
    .rdData  (regRdData),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] pinIn = '0;
  logic         regWrEn = 1'b0;
  logic [2:0]   regAddr = 3'd0;
  logic [N-1:0] regWrData = '0;
  logic [N-1:0] regRdData;
  logic [N-1:0] irqOut;

  typedef struct {
    logic [N-1:0] expRd;
    logic [N-1:0] expIrq;
    string        tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_unit #(.NUM_PINS(N)) uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  // Monitor: compare just after each rising edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (regRdData !== it.expRd) begin
        failures++;
        $display("FAIL %s rd actual=%h expected=%h", it.tag, regRdData, it.expRd);
      end
      checks++;
      if (irqOut !== it.expIrq) begin
        failures++;
        $display("FAIL %s irq actual=%h expected=%h", it.tag, irqOut, it.expIrq);
      end
    end
  end

  task automatic step(input bit wr, input logic [2:0] addr, input logic [N-1:0] data,
                      input logic [N-1:0] pins, input logic [N-1:0] expRd,
                      input logic [N-1:0] expIrq, input string tag);
    expItem_t it;
    @(negedge clk);
    regWrEn = wr;
    regAddr = addr;
    regWrData = data;
    pinIn = pins;
    it.expRd = expRd;
    it.expIrq = expIrq;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  initial begin
    pinIn = 32'h1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 0, 32'h1, 0, 0, "R1 reset state");
    step(1, 3, 32'hFF, 32'h1, 32'hFF, 0, "R11 rise enable readback");
    step(0, 0, 0, 32'h1, 0, 0, "R10 no edge after reset");
    step(1, 1, 32'hFFFF, 32'h1, 32'hFFFF, 0, "R11 enable readback");
    step(0, 0, 0, 32'h101, 0, 0, "R5 rise on disabled pin");
    step(0, 0, 0, 32'h103, 32'h2, 32'h2, "R2 rising edge");
    step(1, 0, 0, 32'h103, 32'h2, 32'h2, "R6 zero write keeps");
    step(1, 0, 32'h2, 32'h103, 0, 0, "R6 one write clears");
    step(1, 4, 32'hFF00, 32'h103, 32'hFF00, 0, "R11 fall enable readback");
    step(0, 0, 0, 32'h003, 32'h100, 32'h100, "R3 falling edge");
    step(0, 0, 0, 32'h103, 32'h100, 32'h100, "R5 rise not enabled");
    step(1, 0, 32'h100, 32'h103, 0, 0, "R6 clear fall bit");
    step(1, 5, 32'h10000, 32'h103, 32'h10000, 0, "R11 high enable readback");
    step(0, 0, 0, 32'h10103, 32'h10000, 0, "R9 masked level high");
    step(1, 0, 32'h10000, 32'h10103, 32'h10000, 0, "R4 clear during level");
    step(0, 0, 0, 32'h00103, 32'h10000, 0, "R4 level gone state kept");
    step(1, 0, 32'h10000, 32'h103, 0, 0, "R4 clear after level");
    step(1, 6, 32'h20000, 32'h103, 32'h20000, 0, "R11 low enable readback");
    step(0, 0, 0, 32'h103, 32'h20000, 0, "R4 level low");
    step(1, 1, 32'h2FFFF, 32'h20103, 32'h2FFFF, 32'h20000, "R9 enable unmasks");
    step(1, 0, 32'h20000, 32'h20103, 0, 0, "R6 clear low bit");
    step(1, 2, 32'h80000001, 32'h20103, 0, 0, "R8 test reads zero");
    step(0, 0, 0, 32'h20103, 32'h80000001, 32'h1, "R8 test applied");
    step(1, 0, 32'h80000001, 32'h20103, 0, 0, "R6 clear test bits");
    step(0, 0, 0, 32'h20103, 0, 0, "R8 test self cleared");
    step(1, 3, 0, 32'h20103, 0, 0, "R11 rise disabled readback");
    step(0, 0, 0, 32'h20100, 0, 0, "R5 fall disabled");
    step(0, 0, 0, 32'h20103, 0, 0, "R5 rise disabled");
    step(1, 3, 32'h2, 32'h20101, 32'h2, 0, "R11 rise bit1 readback");
    step(1, 0, 32'h2, 32'h20103, 32'h2, 32'h2, "R7 set beats clear");
    step(0, 0, 0, 32'h20103, 32'h2, 32'h2, "R7 bit stays");
    @(negedge clk);
    regWrEn = 1'b0;
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule